// File: doc/BRIEF.md
# Clock Divider SYNC Pulse Sequencer

This block drives the SYNC trigger that lines up the divided outputs of an external clock buffer. It fires once after each completed configuration of the buffer, and once for each later event that can leave the buffer's dividers out of phase: a divider rewrite, a power restore, or an input clock that went missing for a while. It never pulses on its own, so in steady state SYNC stays low.

The buffer requires each SYNC pulse to stay high for a minimum number of its input clock cycles, and requires a minimum number of those cycles between rising edges. The block runs on a local clock that may be slower than the buffer's input clock. The parameter `REF_PER_LCL` gives how many reference cycles fit in one local cycle. Both limits are turned into local cycles, rounding up: HIGH_L = ceil(REF_HIGH / REF_PER_LCL) and SPACE_L = ceil(REF_SPACE / REF_PER_LCL).

A request that comes in while a pulse is under way is held. It is served as soon as the spacing guard has run out, and any number of such requests become a single pulse. A busy flag covers each pulse together with its guard, and a one-cycle done strobe marks the end of each guard.

Top module: `syncpulse_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `sync_o`, `busy_o` and `done_o` are low after that edge. Any request held before the reset is dropped, so no pulse follows a reset unless a new request arrives.
- R2: A request is a high level on any of `cfg_done_i`, `div_rewrite_i`, `pwr_restore_i` or `clk_loss_i`. A request sampled while `busy_o` is low sets `sync_o` high at that same edge. `sync_o` is a register and changes only on a rising clock edge.
- R3: Each pulse keeps `sync_o` high for exactly HIGH_L local cycles. With the default reference values of 6 and 75 and a ratio of 4, HIGH_L is 2.
- R4: Two rising edges of `sync_o` are never closer than SPACE_L local cycles (19 with the defaults and a ratio of 4). Take a second request sampled k cycles after the edge that raised the previous pulse, with k of 1 or more. The next rising edge then comes max(SPACE_L, k) cycles after the previous one.
- R5: All requests sampled while `busy_o` is high are merged, and together they produce exactly one further pulse.
- R6: `sync_o` rises only in answer to a request. With no requests there is no pulse at all, however long the block idles.
- R7: `busy_o` is high for SPACE_L cycles for each pulse, starting in the cycle `sync_o` rises. It stays high without a gap when a pulse follows on at once, and it is low when the block is idle.
- R8: `done_o` is high for a single cycle, SPACE_L cycles after each rising edge of `sync_o`. There is one strobe per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done_i | input | 1 | Configuration of the buffer finished |
| div_rewrite_i | input | 1 | Divider settings were rewritten |
| pwr_restore_i | input | 1 | Buffer power came back |
| clk_loss_i | input | 1 | Buffer input clock dropped out and returned |
| sync_o | output | 1 | Registered SYNC trigger to the buffer |
| busy_o | output | 1 | Pulse or spacing guard in progress |
| done_o | output | 1 | One-cycle strobe at the end of each guard |

## Verification
The bench sweeps the gap between two requests from zero to past the spacing limit, and rotates through the four sources as it does so. It checks the exact edge of each rise, the high time, the busy length and the position of the done strobe. A design that served a pending request only after passing through idle would put the second rise one cycle late. A design that dropped a request arriving in the final guard cycle would lose the pulse, and one that ignored spacing would rise early. Separate cases send three requests into one busy window, where a missing merge shows up as extra pulses. Another case resets the block mid-pulse with a request pending, where a pending flag that survives reset would fire a pulse nobody asked for.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_GUARD = 2'd2
    } sps_state_e;

    typedef struct packed {
        sps_state_e st;
        logic       sync;
        logic       done;
    } sps_regs_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sps_req_merge.sv
module sps_req_merge #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src,
    input  logic             capture,
    input  logic             clear,
    output logic             req_now,
    output logic             pend
);
    logic pend_d, pend_q;

    assign req_now = |src;

    always_comb begin
        pend_d = pend_q;
        if (clear) begin
            pend_d = 1'b0;
        end else if (capture && req_now) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/sps_interval_timer.sv
module sps_interval_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/syncpulse_seq.sv
module syncpulse_seq
    import sps_pkg::*;
#(
    parameter int REF_HIGH    = 6,
    parameter int REF_SPACE   = 75,
    parameter int REF_PER_LCL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_done_i,
    input  logic div_rewrite_i,
    input  logic pwr_restore_i,
    input  logic clk_loss_i,
    output logic sync_o,
    output logic busy_o,
    output logic done_o
);
    localparam int N_SRC   = 4;
    localparam int HIGH_L  = int'(ceil_div(REF_HIGH, REF_PER_LCL));
    localparam int SPACE_L = int'(ceil_div(REF_SPACE, REF_PER_LCL));
    localparam int GUARD_L = (SPACE_L > HIGH_L) ? (SPACE_L - HIGH_L) : 1;
    localparam int MAX_L   = (HIGH_L > GUARD_L) ? HIGH_L : GUARD_L;
    localparam int CNT_W   = $clog2(MAX_L + 1);

    localparam logic [CNT_W-1:0] HIGH_LOAD  = CNT_W'(HIGH_L - 1);
    localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_L - 1);

    sps_regs_t r_d, r_q;

    logic             req_now, pend, capture, clear;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    sps_req_merge #(.N_SRC(N_SRC)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .src     ({clk_loss_i, pwr_restore_i, div_rewrite_i, cfg_done_i}),
        .capture (capture),
        .clear   (clear),
        .req_now (req_now),
        .pend    (pend)
    );

    sps_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        clear    = 1'b0;
        capture  = (r_q.st != ST_IDLE);
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_now) begin
                    r_d.st   = ST_HIGH;
                    r_d.sync = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = HIGH_LOAD;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    r_d.st   = ST_GUARD;
                    r_d.sync = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = GUARD_LOAD;
                end
            end
            ST_GUARD: begin
                if (tmr_zero) begin
                    r_d.done = 1'b1;
                    if (pend || req_now) begin
                        r_d.st   = ST_HIGH;
                        r_d.sync = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = HIGH_LOAD;
                        clear    = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.sync = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.sync <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o = r_q.sync;
    assign done_o = r_q.done;
    assign busy_o = (r_q.st != ST_IDLE);
endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
#(
    parameter int REF_HIGH    = 6,
    parameter int REF_SPACE   = 75,
    parameter int REF_PER_LCL = 4
) (
    input logic clk,
    input logic rst,
    input logic any_req,
    input logic sync,
    input logic busy,
    input logic done
);
    localparam int HIGH_L  = int'(ceil_div(REF_HIGH, REF_PER_LCL));
    localparam int SPACE_L = int'(ceil_div(REF_SPACE, REF_PER_LCL));
    localparam int W       = $clog2(SPACE_L + 2) + 1;

    logic         sync_prev;
    logic         seen;
    logic [W-1:0] since;
    logic [W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev <= 1'b0;
            seen      <= 1'b0;
            since     <= '0;
            hi_cnt    <= '0;
        end else begin
            sync_prev <= sync;
            if (sync && !sync_prev) begin
                since <= W'(1);
                seen  <= 1'b1;
            end else if (since < W'(SPACE_L + 1)) begin
                since <= since + 1'b1;
            end
            if (sync) begin
                if (hi_cnt < W'(SPACE_L + 1)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sync && !busy && !done)); // R1
    AST_IDLE_REQ_FIRES: assert property (@(posedge clk) disable iff (rst) (any_req && !busy) |=> sync); // R2
    AST_HIGH_TIME: assert property (@(posedge clk) disable iff (rst) (!sync && sync_prev) |-> (hi_cnt == W'(HIGH_L))); // R3
    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst) (sync && !sync_prev) |-> (!seen || since >= W'(SPACE_L))); // R4
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst) $rose(sync) |-> ($past(any_req) || $past(busy))); // R6
    AST_SYNC_IN_BUSY: assert property (@(posedge clk) disable iff (rst) sync |-> busy); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_DONE_AT_SPACE: assert property (@(posedge clk) disable iff (rst) done |-> (since == W'(SPACE_L))); // R8
endmodule

bind syncpulse_seq sps_checker #(
    .REF_HIGH    (REF_HIGH),
    .REF_SPACE   (REF_SPACE),
    .REF_PER_LCL (REF_PER_LCL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .any_req (cfg_done_i | div_rewrite_i | pwr_restore_i | clk_loss_i),
    .sync    (sync_o),
    .busy    (busy_o),
    .done    (done_o)
);

// File: tb/syncpulse_seq_tb.sv
module syncpulse_seq_tb;
    localparam int RH = 6;
    localparam int RS = 75;
    localparam int RT = 4;
    localparam int EH = (RH + RT - 1) / RT;
    localparam int ES = (RS + RT - 1) / RT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reqv = 4'b0;
    logic       sync_o, busy_o, done_o;

    always #2 clk = ~clk;

    syncpulse_seq #(.REF_HIGH(RH), .REF_SPACE(RS), .REF_PER_LCL(RT)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_done_i    (reqv[0]),
        .div_rewrite_i (reqv[1]),
        .pwr_restore_i (reqv[2]),
        .clk_loss_i    (reqv[3]),
        .sync_o        (sync_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    int rises[8];
    int nr, hi_tot, busy_tot, nd, first_done;
    logic prev_s = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sync_o && !prev_s && nr < 8) begin
            rises[nr] = cyc;
            nr++;
        end
        if (sync_o) hi_tot++;
        if (busy_o) busy_tot++;
        if (done_o) begin
            if (nd == 0) first_done = cyc;
            nd++;
        end
        prev_s = sync_o;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nr = 0; hi_tot = 0; busy_tot = 0; nd = 0; first_done = -1;
        for (int i = 0; i < 8; i++) rises[i] = -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        reqv = 4'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_mon();
    endtask

    task automatic sweep_case(input int k);
        int a, s1, s2, n_exp, gap;
        s1 = k % 4;
        s2 = (k + 1) % 4;
        do_reset();
        a = cyc;
        reqv[s1] = 1'b1;
        if (k == 0) reqv[s2] = 1'b1;
        @(negedge clk);
        reqv = 4'b0;
        if (k > 0) begin
            repeat (k - 1) @(negedge clk);
            reqv[s2] = 1'b1;
            @(negedge clk);
            reqv = 4'b0;
        end
        repeat (80) @(negedge clk);
        n_exp = (k == 0) ? 1 : 2;
        gap = (k > ES) ? k : ES;
        check("R6", $sformatf("k=%0d pulse count", k), nr, n_exp);
        check("R2", $sformatf("k=%0d first rise cycle", k), rises[0], a + 1);
        if (k > 0) check("R4", $sformatf("k=%0d rise spacing", k), rises[1] - rises[0], gap);
        check("R3", $sformatf("k=%0d high cycles", k), hi_tot, EH * n_exp);
        check("R7", $sformatf("k=%0d busy cycles", k), busy_tot, ES * n_exp);
        check("R8", $sformatf("k=%0d done count", k), nd, n_exp);
        check("R8", $sformatf("k=%0d first done cycle", k), first_done, a + 1 + ES);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int a;
        // R1: outputs quiet while reset is held
        clear_mon();
        repeat (2) @(negedge clk);
        check("R1", "sync in reset", int'(sync_o), 0);
        check("R1", "busy in reset", int'(busy_o), 0);
        check("R1", "done in reset", int'(done_o), 0);
        rst = 1'b0;

        // R6: long idle with no request gives no pulse
        clear_mon();
        repeat (150) @(negedge clk);
        check("R6", "idle pulse count", nr, 0);
        check("R7", "idle busy cycles", busy_tot, 0);

        // R2..R8: sweep request gap and sources
        for (int k = 0; k <= ES + 5; k++) sweep_case(k);

        // R5: three requests inside one busy window merge into one pulse
        do_reset();
        a = cyc;
        reqv[0] = 1'b1; @(negedge clk); reqv = 4'b0;
        repeat (2) @(negedge clk);
        reqv[1] = 1'b1; @(negedge clk); reqv = 4'b0;
        repeat (4) @(negedge clk);
        reqv[2] = 1'b1; reqv[3] = 1'b1; @(negedge clk); reqv = 4'b0;
        repeat (6) @(negedge clk);
        reqv[1] = 1'b1; @(negedge clk); reqv = 4'b0;
        repeat (90) @(negedge clk);
        check("R5", "merged pulse count", nr, 2);
        check("R5", "merged second rise", rises[1], a + 1 + ES);
        check("R5", "merged done count", nd, 2);

        // R1: reset mid-pulse with a pending request drops everything
        do_reset();
        reqv[2] = 1'b1; @(negedge clk); reqv = 4'b0;
        @(negedge clk);
        reqv[3] = 1'b1; @(negedge clk); reqv = 4'b0;
        rst = 1'b1; @(negedge clk);
        check("R1", "sync after mid-pulse reset", int'(sync_o), 0);
        check("R1", "busy after mid-pulse reset", int'(busy_o), 0);
        rst = 1'b0;
        clear_mon();
        repeat (100) @(negedge clk);
        check("R1", "pulses after reset with pending", nr, 0);
        check("R1", "done after reset with pending", nd, 0);

        // R2: each source alone starts a pulse from idle
        for (int s = 0; s < 4; s++) begin
            do_reset();
            a = cyc;
            reqv[s] = 1'b1; @(negedge clk); reqv = 4'b0;
            repeat (30) @(negedge clk);
            check("R2", $sformatf("source %0d rise cycle", s), rises[0], a + 1);
            check("R6", $sformatf("source %0d pulse count", s), nr, 1);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule